// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two data buses, A and B, through a 16-bit path. The path is split into two 8-bit halves, and each half has its own control set. Each half has an active-low output enable and a direction input. It also has a capture strobe for each direction, which loads the level on A into an A-side store or the level on B into a B-side store. For each direction there is a select input that chooses whether the driven bus carries live data from the opposite bus or the stored value. When the enable is high, neither bus is driven, but both stores can still capture.

Each bidirectional pin is modelled as three signals: a pad input, an output, and a per-bit drive enable. A per-half flag tells the block whether some outside agent is currently driving that half of a bus. A per-pin keeper records the resolved level at every clock edge. A pin that nobody drives therefore reads as its last active level. Capture strobes are sampled on the block clock, and a store loads on the cycle where its strobe goes from low to high.

Top module: `bus_xcvr_reg`

## Requirements
- R1: The two 8-bit halves (bits 7:0 and bits 15:8) work independently. A control input of one half never changes the drive enables, the outputs or the stores of the other half.
- R2: At a clock edge where a half's `cap_ab_i` bit is 1 and was 0 at the previous edge, that half's A store loads the current A pin level. While the strobe stays high, the store keeps its value.
- R3: The same rule as R2 applies to `cap_ba_i`, the B store and the B pin level.
- R4: While a half's `oe_ni` is 1, neither bus drives in that half (all drive enables are 0). Captures into both stores still take place in that state.
- R5: While a half's `oe_ni` is 0, `dir_i`=1 drives B, so all of that half's `b_oe_o` bits are 1 and its `a_oe_o` bits are 0. `dir_i`=0 drives A the same way.
- R6: When B is driven, `sel_ab_i`=0 puts live A data on `b_o` in the same cycle, and `sel_ab_i`=1 puts the A store on `b_o`.
- R7: When A is driven, `sel_ba_i`=0 puts live B data on `a_o`, and `sel_ba_i`=1 puts the B store on `a_o`.
- R8: No bit ever has `a_oe_o` and `b_oe_o` both at 1.
- R9: When a half of a pin is driven neither by the block nor from outside (its ext flag is 0), its output holds the level it had at the last clock edge. That level is the last driven or externally applied value.
- R10: On any driven bit, the output equals either the live value or the stored value of the selected direction, so a select change never yields any third value.
- R11: After reset (`rst_ni` low), both stores and both keepers are 0 and the strobe history is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| oe_ni | input | 2 | Per-half output enable, active low |
| dir_i | input | 2 | Per-half direction, 1 = A to B |
| cap_ab_i | input | 2 | Per-half A-store capture strobe |
| cap_ba_i | input | 2 | Per-half B-store capture strobe |
| sel_ab_i | input | 2 | Per-half B-bus source, 1 = stored |
| sel_ba_i | input | 2 | Per-half A-bus source, 1 = stored |
| a_i | input | 16 | A pad input level |
| a_ext_i | input | 2 | Per-half flag: an outside agent drives A |
| b_i | input | 16 | B pad input level |
| b_ext_i | input | 2 | Per-half flag: an outside agent drives B |
| a_o | output | 16 | Resolved A pin level (driven, external or kept) |
| a_oe_o | output | 16 | A per-bit drive enable |
| b_o | output | 16 | Resolved B pin level (driven, external or kept) |
| b_oe_o | output | 16 | B per-bit drive enable |

## Verification
The stores are loaded with data patterns whose halves differ (A5/5A, C3E1, 9D42, 2468). A value that moved to the wrong half or came from the wrong store therefore shows up at once. In each transfer case the live input is changed after capture, so the stored value and the live value always differ; this tells the select paths apart. A strobe held high across a data change separates edge capture from level capture. The select toggle test uses complementary patterns (0F0F and F0F0), so any bit mixing between the two sources is visible. A sweep over all combinations of enable and direction confirms that the drive is exclusive and that the halves are independent.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef struct packed {
    logic oe_n;
    logic dir;
    logic cap_ab;
    logic cap_ba;
    logic sel_ab;
    logic sel_ba;
  } half_ctl_t;
endpackage

// File: rtl/bxr_store.sv
module bxr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic strobe_q;
  logic take;

  assign take = strobe_i & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      q_o      <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (take) q_o <= d_i;
    end
  end
endmodule

// File: rtl/bxr_keeper.sv
module bxr_keeper #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= lvl_i;
  end
endmodule

// File: rtl/bxr_half.sv
module bxr_half
  import bxr_pkg::*;
#(
  parameter int HALF_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  half_ctl_t         ctl_i,
  input  logic [HALF_W-1:0] a_i,
  input  logic              a_ext_i,
  input  logic [HALF_W-1:0] b_i,
  input  logic              b_ext_i,
  output logic [HALF_W-1:0] a_o,
  output logic [HALF_W-1:0] a_oe_o,
  output logic [HALF_W-1:0] b_o,
  output logic [HALF_W-1:0] b_oe_o,
  output logic [HALF_W-1:0] a_q_o,
  output logic [HALF_W-1:0] b_q_o,
  output logic [HALF_W-1:0] a_live_o,
  output logic [HALF_W-1:0] b_live_o
);
  logic              drv_a, drv_b;
  logic [HALF_W-1:0] a_hold, b_hold;
  logic [HALF_W-1:0] a_val, b_val;

  assign drv_a = ~ctl_i.oe_n & ~ctl_i.dir;
  assign drv_b = ~ctl_i.oe_n &  ctl_i.dir;

  // live level of a pin as seen from outside the block
  assign a_live_o = a_ext_i ? a_i : a_hold;
  assign b_live_o = b_ext_i ? b_i : b_hold;

  // single select bit per half: output is always exactly one source
  assign b_val = ctl_i.sel_ab ? a_q_o : a_live_o;
  assign a_val = ctl_i.sel_ba ? b_q_o : b_live_o;

  assign a_o    = drv_a ? a_val : a_live_o;
  assign b_o    = drv_b ? b_val : b_live_o;
  assign a_oe_o = {HALF_W{drv_a}};
  assign b_oe_o = {HALF_W{drv_b}};

  bxr_store #(.W(HALF_W)) u_store_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(ctl_i.cap_ab), .d_i(a_o), .q_o(a_q_o)
  );
  bxr_store #(.W(HALF_W)) u_store_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .strobe_i(ctl_i.cap_ba), .d_i(b_o), .q_o(b_q_o)
  );
  bxr_keeper #(.W(HALF_W)) u_keep_a (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(a_o), .q_o(a_hold)
  );
  bxr_keeper #(.W(HALF_W)) u_keep_b (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(b_o), .q_o(b_hold)
  );
endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bxr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int N_HALF = 2,
  localparam int W = HALF_W * N_HALF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_HALF-1:0] oe_ni,
  input  logic [N_HALF-1:0] dir_i,
  input  logic [N_HALF-1:0] cap_ab_i,
  input  logic [N_HALF-1:0] cap_ba_i,
  input  logic [N_HALF-1:0] sel_ab_i,
  input  logic [N_HALF-1:0] sel_ba_i,
  input  logic [W-1:0]      a_i,
  input  logic [N_HALF-1:0] a_ext_i,
  input  logic [W-1:0]      b_i,
  input  logic [N_HALF-1:0] b_ext_i,
  output logic [W-1:0]      a_o,
  output logic [W-1:0]      a_oe_o,
  output logic [W-1:0]      b_o,
  output logic [W-1:0]      b_oe_o
);
  logic [W-1:0] a_q_w, b_q_w, a_live_w, b_live_w;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    half_ctl_t ctl;
    assign ctl = '{oe_n: oe_ni[h], dir: dir_i[h], cap_ab: cap_ab_i[h],
                   cap_ba: cap_ba_i[h], sel_ab: sel_ab_i[h], sel_ba: sel_ba_i[h]};

    bxr_half #(.HALF_W(HALF_W)) u_half (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_i    (ctl),
      .a_i      (a_i[h*HALF_W +: HALF_W]),
      .a_ext_i  (a_ext_i[h]),
      .b_i      (b_i[h*HALF_W +: HALF_W]),
      .b_ext_i  (b_ext_i[h]),
      .a_o      (a_o[h*HALF_W +: HALF_W]),
      .a_oe_o   (a_oe_o[h*HALF_W +: HALF_W]),
      .b_o      (b_o[h*HALF_W +: HALF_W]),
      .b_oe_o   (b_oe_o[h*HALF_W +: HALF_W]),
      .a_q_o    (a_q_w[h*HALF_W +: HALF_W]),
      .b_q_o    (b_q_w[h*HALF_W +: HALF_W]),
      .a_live_o (a_live_w[h*HALF_W +: HALF_W]),
      .b_live_o (b_live_w[h*HALF_W +: HALF_W])
    );
  end
endmodule

// File: rtl/bxr_chk.sv
module bxr_chk #(
  parameter int HALF_W = 8,
  parameter int N_HALF = 2,
  localparam int W = HALF_W * N_HALF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [N_HALF-1:0] oe_ni,
  input logic [N_HALF-1:0] dir_i,
  input logic [N_HALF-1:0] cap_ab_i,
  input logic [N_HALF-1:0] cap_ba_i,
  input logic [N_HALF-1:0] a_ext_i,
  input logic [N_HALF-1:0] b_ext_i,
  input logic [W-1:0]      a_o,
  input logic [W-1:0]      a_oe_o,
  input logic [W-1:0]      b_o,
  input logic [W-1:0]      b_oe_o,
  input logic [W-1:0]      a_q_w,
  input logic [W-1:0]      b_q_w,
  input logic [W-1:0]      a_live_w,
  input logic [W-1:0]      b_live_w
);
  // R8
  no_dual_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o & b_oe_o) == '0);

  // R10
  b_clean_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((b_o ^ a_live_w) & (b_o ^ a_q_w) & b_oe_o) == '0);

  // R10
  a_clean_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((a_o ^ b_live_w) & (a_o ^ b_q_w) & a_oe_o) == '0);

  for (genvar h = 0; h < N_HALF; h++) begin : g_h
    // R4
    isolate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      oe_ni[h] |-> (a_oe_o[h*HALF_W +: HALF_W] == '0 && b_oe_o[h*HALF_W +: HALF_W] == '0));

    // R5
    dir_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !oe_ni[h] |-> (b_oe_o[h*HALF_W +: HALF_W] == {HALF_W{dir_i[h]}} &&
                     a_oe_o[h*HALF_W +: HALF_W] == {HALF_W{!dir_i[h]}}));

    // R2
    cap_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cap_ab_i[h]) |=> a_q_w[h*HALF_W +: HALF_W] == $past(a_o[h*HALF_W +: HALF_W]));

    // R3
    cap_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(cap_ba_i[h]) |=> b_q_w[h*HALF_W +: HALF_W] == $past(b_o[h*HALF_W +: HALF_W]));

    // R9
    a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (a_oe_o[h*HALF_W] == 1'b0 && !a_ext_i[h]) |=>
      (a_oe_o[h*HALF_W] || a_ext_i[h] || $stable(a_o[h*HALF_W +: HALF_W])));

    // R9
    b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (b_oe_o[h*HALF_W] == 1'b0 && !b_ext_i[h]) |=>
      (b_oe_o[h*HALF_W] || b_ext_i[h] || $stable(b_o[h*HALF_W +: HALF_W])));
  end
endmodule

bind bus_xcvr_reg bxr_chk #(.HALF_W(HALF_W), .N_HALF(N_HALF)) u_chk (.*);

// File: tb/tb_bus_xcvr_reg.sv
module tb_bus_xcvr_reg;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  oe_ni = 2'b11, dir_i = '0, cap_ab_i = '0, cap_ba_i = '0;
  logic [1:0]  sel_ab_i = '0, sel_ba_i = '0, a_ext_i = '0, b_ext_i = '0;
  logic [15:0] a_i = '0, b_i = '0;
  logic [15:0] a_o, a_oe_o, b_o, b_oe_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk_i = ~clk_i;

  bus_xcvr_reg dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk("R11 a_oe", a_oe_o, 16'h0000);
    chk("R11 b_oe", b_oe_o, 16'h0000);
    chk("R11 a_o keeper", a_o, 16'h0000);
    chk("R11 b_o keeper", b_o, 16'h0000);
    oe_ni = 2'b00; dir_i = 2'b11; sel_ab_i = 2'b11; #1;
    chk("R11 A store", b_o, 16'h0000);
    oe_ni = 2'b11; sel_ab_i = 2'b00; nxt();
  endtask

  task automatic t_store_a();
    a_ext_i = 2'b01; a_i = 16'h00A5; cap_ab_i = 2'b01; nxt();
    a_i = 16'h003C; nxt();        // strobe still high: no reload
    cap_ab_i = 2'b00; nxt();
    oe_ni = 2'b10; dir_i = 2'b01; sel_ab_i = 2'b01; #1;
    chk("R5 b_oe half0", b_oe_o, 16'h00FF);
    chk("R5 a_oe half0", a_oe_o, 16'h0000);
    chk("R2 stored A edge only", b_o[7:0], 8'hA5);
    sel_ab_i = 2'b00; #1;
    chk("R6 live A", b_o[7:0], 8'h3C);
    a_i = 16'h0077; #1;
    chk("R6 live A follows", b_o[7:0], 8'h77);
    nxt(); oe_ni = 2'b11; nxt();
  endtask

  task automatic t_store_b();
    b_ext_i = 2'b10; b_i = 16'h5A00; cap_ba_i = 2'b10; nxt();
    cap_ba_i = 2'b00; b_i = 16'h1100; nxt();
    oe_ni = 2'b01; dir_i = 2'b00; sel_ba_i = 2'b10; #1;
    chk("R5 a_oe half1", a_oe_o, 16'hFF00);
    chk("R3 R7 stored B", a_o[15:8], 8'h5A);
    sel_ba_i = 2'b00; #1;
    chk("R7 live B", a_o[15:8], 8'h11);
    nxt(); oe_ni = 2'b11; nxt();
  endtask

  task automatic t_isolation();
    a_ext_i = 2'b11; b_ext_i = 2'b11; a_i = 16'hC3E1; b_i = 16'h9D42;
    cap_ab_i = 2'b11; cap_ba_i = 2'b11; nxt();
    chk("R4 no A drive", a_oe_o, 16'h0000);
    chk("R4 no B drive", b_oe_o, 16'h0000);
    cap_ab_i = 2'b00; cap_ba_i = 2'b00; a_i = 16'h0000; b_i = 16'h0000; nxt();
    oe_ni = 2'b00; dir_i = 2'b11; sel_ab_i = 2'b11; #1;
    chk("R4 A captured in isolation", b_o, 16'hC3E1);
    dir_i = 2'b00; sel_ba_i = 2'b11; #1;
    chk("R4 B captured in isolation", a_o, 16'h9D42);
    nxt(); oe_ni = 2'b11; sel_ab_i = '0; sel_ba_i = '0; nxt();
  endtask

  task automatic t_independent();
    oe_ni = 2'b00; dir_i = 2'b01; #1;
    chk("R1 b_oe split", b_oe_o, 16'h00FF);
    chk("R1 a_oe split", a_oe_o, 16'hFF00);
    nxt(); oe_ni = 2'b11; nxt();
    a_ext_i = 2'b11; a_i = 16'h2468; cap_ab_i = 2'b10; nxt();
    cap_ab_i = 2'b00; nxt();
    oe_ni = 2'b00; dir_i = 2'b11; sel_ab_i = 2'b11; #1;
    chk("R1 capture one half", b_o, 16'h24E1);
    nxt(); oe_ni = 2'b11; sel_ab_i = '0; nxt();
  endtask

  task automatic t_bus_hold();
    a_ext_i = 2'b11; b_ext_i = 2'b00; a_i = 16'hBEEF; nxt();
    a_ext_i = 2'b00; a_i = 16'h0000; #1;
    chk("R9 A kept", a_o, 16'hBEEF);
    nxt();
    chk("R9 A kept later", a_o, 16'hBEEF);
    a_ext_i = 2'b11; a_i = 16'h1234; oe_ni = 2'b00; dir_i = 2'b11; sel_ab_i = 2'b00; nxt();
    oe_ni = 2'b11; nxt();
    chk("R9 B keeps driven level", b_o, 16'h1234);
  endtask

  task automatic t_sel_switch();
    a_ext_i = 2'b11; a_i = 16'h0F0F; cap_ab_i = 2'b11; nxt();
    cap_ab_i = 2'b00; a_i = 16'hF0F0; oe_ni = 2'b00; dir_i = 2'b11; nxt();
    for (int k = 0; k < 6; k++) begin
      sel_ab_i = (k % 2 == 0) ? 2'b11 : 2'b00; #1;
      chk("R10 select toggle", b_o, (k % 2 == 0) ? 16'h0F0F : 16'hF0F0);
      #(CLK_P/2);
    end
    sel_ab_i = 2'b01; #1;
    chk("R10 mixed select", b_o, 16'hF00F);
    nxt(); oe_ni = 2'b11; sel_ab_i = '0; nxt();
  endtask

  task automatic t_drive_sweep();
    for (int m = 0; m < 16; m++) begin
      oe_ni = m[1:0]; dir_i = m[3:2]; #1;
      chk("R8 exclusive drive", a_oe_o & b_oe_o, 16'h0000);
      chk("R5 R1 b_oe pattern", b_oe_o,
          {{8{~oe_ni[1] & dir_i[1]}}, {8{~oe_ni[0] & dir_i[0]}}});
      #(CLK_P);
    end
    oe_ni = 2'b11; nxt();
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) nxt();
    rst_ni = 1'b1; nxt();
    t_reset();
    t_store_a();
    t_store_b();
    t_isolation();
    t_independent();
    t_bus_hold();
    t_sel_switch();
    t_drive_sweep();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule